// File: doc/BRIEF.md
# Leaky-Bucket Rank Error Counter Bank

The block counts memory error events per rank in two banks of small saturating counters. One bank holds correctable errors and the other holds uncorrectable errors. Each error event carries a rank index and a class. An aliased uncorrectable event is treated as correctable, so it is steered into the correctable bank.

A free-running period timer produces a leak tick. On each tick, every non-zero counter that is not frozen loses one count. Old errors therefore drain away, and only a burst of errors drives a counter upward. When an increment brings a counter to the programmed freeze level, the counter locks at that value. A sticky status flag is raised in the same cycle.

Software reads both banks as packed words. It writes all-ones into a nibble to clear and unlock that counter. It clears the status flag by writing one to its clear input.

Top module: `err_bucket_bank`

## Requirements
- R1: After a synchronous reset, both words are zero and `thr_hit` is 0. Rank r's count sits in bits 4r+3:4r of its word. With the defaults, rank 0 is in bits 3:0 and rank 7 is in bits 31:28.
- R2: An event with `ev_valid`=1 adds one to the count of rank `ev_rank`, and the class selects the bank. Class 0 (correctable) and class 2 (aliased uncorrectable) add to `ce_word` only. Class 1 (uncorrectable) adds to `ue_word` only. Class 3 changes neither word.
- R3: A count of 15 stays at 15 on further events and never wraps.
- R4: The period counter resets to 0 and advances by one per cycle. In any cycle where it is at or above a non-zero `period_limit`, `leak_tick` is 1 and the counter returns to 0. Every non-zero, unfrozen count is then decremented in that cycle. With `period_limit`=0, `leak_tick` stays 0 and nothing leaks.
- R5: A write with `sw_wr_en`=1 targets one bank: `sw_wr_sel`=0 selects the correctable bank and 1 selects the uncorrectable bank. Every rank nibble of `sw_wr_data` equal to 4'hF clears that count to 0 and unfreezes it. Nibbles with any other value leave their counts unchanged.
- R6: When a count of c is incremented, with no leak at that field, and c+1 equals a non-zero `frz_thresh`, the count freezes at c+1. A frozen count ignores both events and leak ticks. A `frz_thresh` of 0 never freezes a count.
- R7: Changing `frz_thresh` neither unfreezes a frozen count nor changes its value.
- R8: If an event and a leak tick reach the same non-zero, unsaturated, unfrozen count in the same cycle, the count is unchanged. At 15 the same combination yields 14. At 0 it yields 1.
- R9: `thr_hit` becomes 1 one clock after any count freezes. It holds through thawing. It clears one clock after `sts_clr`=1, unless a new freeze happens in that same cycle, in which case it stays 1.
- R10: An all-ones write to a nibble takes precedence over an event and a leak tick arriving at the same count in the same cycle, and the count becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Error event strobe |
| ev_rank | input | 3 | Rank of the event |
| ev_class | input | 2 | Event class: 0 correctable, 1 uncorrectable, 2 aliased, 3 reserved |
| frz_thresh | input | 4 | Freeze level, 0 disables freezing |
| period_limit | input | 16 | Leak period limit, 0 disables leaking |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_sel | input | 1 | Write target: 0 correctable bank, 1 uncorrectable bank |
| sw_wr_data | input | 32 | Write data, nibble 4'hF clears that rank |
| sts_clr | input | 1 | Write-one-to-clear for `thr_hit` |
| leak_tick | output | 1 | Leak tick of the current cycle |
| ce_word | output | 32 | Packed correctable counts |
| ue_word | output | 32 | Packed uncorrectable counts |
| thr_hit | output | 1 | Sticky freeze status |

## Verification
The bench uses eight ranks and 4-bit counts, as in the default build. It narrows the period counter to 8 bits, so that leak periods of three or four cycles can be programmed. With such short periods, the bench drains several counters to zero, shows that frozen counts survive many ticks, and aligns events with ticks on purpose. Freeze levels of 2, 5 and 9 cover freezing in both banks, as well as a threshold change after freezing.

// File: rtl/ebb_pkg.sv
package ebb_pkg;
  typedef enum logic [1:0] {
    EV_CORR   = 2'd0,
    EV_UNCORR = 2'd1,
    EV_ALIAS  = 2'd2,
    EV_RSVD   = 2'd3
  } ev_class_e;
endpackage

// File: rtl/ebb_period_timer.sv
module ebb_period_timer #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PER_W-1:0] limit,
  output logic             tick
);
  logic [PER_W-1:0] cnt_q;
  logic             enabled;

  assign enabled = (limit != '0);
  assign tick    = enabled && (cnt_q >= limit);

  always_ff @(posedge clk) begin
    if (rst || !enabled) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ebb_bucket_field.sv
module ebb_bucket_field #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             leak,
  input  logic             clr,
  input  logic [CNT_W-1:0] thr,
  output logic [CNT_W-1:0] cnt,
  output logic             frz_evt
);
  localparam logic [CNT_W-1:0] FULL = '1;

  logic [CNT_W-1:0] cnt_q, cnt_nxt, cnt_up;
  logic             frz_q, up, dn;

  assign up     = inc && (cnt_q != FULL);
  assign dn     = leak && (cnt_q != '0);
  assign cnt_up = cnt_q + 1'b1;

  always_comb begin
    cnt_nxt = cnt_q;
    if (up && !dn)      cnt_nxt = cnt_up;
    else if (dn && !up) cnt_nxt = cnt_q - 1'b1;
  end

  assign frz_evt = !clr && !frz_q && up && !dn &&
                   (thr != '0) && (cnt_up == thr);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
      frz_q <= 1'b0;
    end else if (!frz_q) begin
      cnt_q <= cnt_nxt;
      if (frz_evt) frz_q <= 1'b1;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/ebb_bucket_set.sv
module ebb_bucket_set #(
  parameter int NUM_RANKS = 8,
  parameter int CNT_W     = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_RANKS-1:0]       inc_vec,
  input  logic                       leak,
  input  logic [NUM_RANKS-1:0]       clr_vec,
  input  logic [CNT_W-1:0]           thr,
  output logic [NUM_RANKS*CNT_W-1:0] word,
  output logic                       frz_any
);
  logic [NUM_RANKS-1:0] frz_vec;

  for (genvar g = 0; g < NUM_RANKS; g++) begin : g_field
    ebb_bucket_field #(.CNT_W(CNT_W)) u_field (
      .clk     (clk),
      .rst     (rst),
      .inc     (inc_vec[g]),
      .leak    (leak),
      .clr     (clr_vec[g]),
      .thr     (thr),
      .cnt     (word[g*CNT_W +: CNT_W]),
      .frz_evt (frz_vec[g])
    );
  end

  assign frz_any = |frz_vec;
endmodule

// File: rtl/err_bucket_bank.sv
module err_bucket_bank #(
  parameter int NUM_RANKS = 8,
  parameter int CNT_W     = 4,
  parameter int PER_W     = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ev_valid,
  input  logic [$clog2(NUM_RANKS)-1:0] ev_rank,
  input  logic [1:0]                 ev_class,
  input  logic [CNT_W-1:0]           frz_thresh,
  input  logic [PER_W-1:0]           period_limit,
  input  logic                       sw_wr_en,
  input  logic                       sw_wr_sel,
  input  logic [NUM_RANKS*CNT_W-1:0] sw_wr_data,
  input  logic                       sts_clr,
  output logic                       leak_tick,
  output logic [NUM_RANKS*CNT_W-1:0] ce_word,
  output logic [NUM_RANKS*CNT_W-1:0] ue_word,
  output logic                       thr_hit
);
  import ebb_pkg::*;
  localparam int RANK_W = $clog2(NUM_RANKS);

  ev_class_e            cls;
  logic                 to_ce, to_ue;
  logic [NUM_RANKS-1:0] ce_inc, ue_inc, ce_clr, ue_clr;
  logic                 ce_frz, ue_frz, hit_q;

  assign cls   = ev_class_e'(ev_class);
  assign to_ce = ev_valid && (cls == EV_CORR || cls == EV_ALIAS);
  assign to_ue = ev_valid && (cls == EV_UNCORR);

  for (genvar g = 0; g < NUM_RANKS; g++) begin : g_dec
    logic hit_rank, nib_full;
    assign hit_rank  = (ev_rank == RANK_W'(g));
    assign nib_full  = (sw_wr_data[g*CNT_W +: CNT_W] == {CNT_W{1'b1}});
    assign ce_inc[g] = to_ce && hit_rank;
    assign ue_inc[g] = to_ue && hit_rank;
    assign ce_clr[g] = sw_wr_en && !sw_wr_sel && nib_full;
    assign ue_clr[g] = sw_wr_en &&  sw_wr_sel && nib_full;
  end

  ebb_period_timer #(.PER_W(PER_W)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .limit (period_limit),
    .tick  (leak_tick)
  );

  ebb_bucket_set #(.NUM_RANKS(NUM_RANKS), .CNT_W(CNT_W)) u_ce (
    .clk     (clk),
    .rst     (rst),
    .inc_vec (ce_inc),
    .leak    (leak_tick),
    .clr_vec (ce_clr),
    .thr     (frz_thresh),
    .word    (ce_word),
    .frz_any (ce_frz)
  );

  ebb_bucket_set #(.NUM_RANKS(NUM_RANKS), .CNT_W(CNT_W)) u_ue (
    .clk     (clk),
    .rst     (rst),
    .inc_vec (ue_inc),
    .leak    (leak_tick),
    .clr_vec (ue_clr),
    .thr     (frz_thresh),
    .word    (ue_word),
    .frz_any (ue_frz)
  );

  always_ff @(posedge clk) begin
    if (rst) hit_q <= 1'b0;
    else     hit_q <= (hit_q && !sts_clr) || ce_frz || ue_frz;
  end

  assign thr_hit = hit_q;
endmodule

// File: rtl/ebb_checker.sv
module ebb_checker #(
  parameter int WORD_W = 32,
  parameter int PER_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              ev_valid,
  input logic [1:0]        ev_class,
  input logic              sw_wr_en,
  input logic              sts_clr,
  input logic [PER_W-1:0]  period_limit,
  input logic              leak_tick,
  input logic [WORD_W-1:0] ce_word,
  input logic [WORD_W-1:0] ue_word,
  input logic              thr_hit
);
  // R1
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> (ce_word == '0 && ue_word == '0 && !thr_hit));

  // R9
  hit_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (thr_hit && !sts_clr) |=> thr_hit);

  // R4
  leak_off_chk: assert property (@(posedge clk) disable iff (rst)
    (period_limit == '0) |-> !leak_tick);

  // R4
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    leak_tick |=> !leak_tick);

  // R2
  quiet_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ev_valid && !sw_wr_en && !leak_tick) |=> ($stable(ce_word) && $stable(ue_word)));

  // R2
  ue_class_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_class != 2'd1 && !sw_wr_en && !leak_tick) |=> $stable(ue_word));
endmodule

bind err_bucket_bank ebb_checker #(
  .WORD_W (NUM_RANKS*CNT_W),
  .PER_W  (PER_W)
) u_ebb_chk (
  .clk          (clk),
  .rst          (rst),
  .ev_valid     (ev_valid),
  .ev_class     (ev_class),
  .sw_wr_en     (sw_wr_en),
  .sts_clr      (sts_clr),
  .period_limit (period_limit),
  .leak_tick    (leak_tick),
  .ce_word      (ce_word),
  .ue_word      (ue_word),
  .thr_hit      (thr_hit)
);

// File: tb/test_err_bucket_bank.sv
module test_err_bucket_bank;
  localparam int CLK_P = 10;
  localparam int NR    = 8;
  localparam int CW    = 4;
  localparam int PW    = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          ev_valid, sw_wr_en, sw_wr_sel, sts_clr;
  logic [2:0]    ev_rank;
  logic [1:0]    ev_class;
  logic [CW-1:0] frz_thresh;
  logic [PW-1:0] period_limit;
  logic [31:0]   sw_wr_data;
  logic          leak_tick, thr_hit;
  logic [31:0]   ce_word, ue_word;

  err_bucket_bank #(.NUM_RANKS(NR), .CNT_W(CW), .PER_W(PW)) i_err_bucket_bank (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_rank(ev_rank),
    .ev_class(ev_class), .frz_thresh(frz_thresh), .period_limit(period_limit),
    .sw_wr_en(sw_wr_en), .sw_wr_sel(sw_wr_sel), .sw_wr_data(sw_wr_data),
    .sts_clr(sts_clr), .leak_tick(leak_tick), .ce_word(ce_word),
    .ue_word(ue_word), .thr_hit(thr_hit)
  );

  always #(CLK_P/2) clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // reference model state
  int m_cnt [2][NR];
  bit m_frz [2][NR];
  bit m_hit;
  int m_tc;
  int n_thr, n_lim;

  logic [64:0] exp_q[$];
  string       tag_q[$];

  function automatic logic [31:0] pack(int s);
    logic [31:0] w = '0;
    for (int r = 0; r < NR; r++) w[r*4 +: 4] = 4'(m_cnt[s][r]);
    return w;
  endfunction

  task automatic step(bit v, int rk, int cl, bit we, bit ws,
                      logic [31:0] wd, bit sc, string tag);
    bit tick, fe;
    @(negedge clk);
    ev_valid = v; ev_rank = 3'(rk); ev_class = 2'(cl);
    sw_wr_en = we; sw_wr_sel = ws; sw_wr_data = wd; sts_clr = sc;
    frz_thresh = 4'(n_thr); period_limit = 8'(n_lim);
    #1;
    tick = (n_lim != 0) && (m_tc >= n_lim);
    total++;
    if (leak_tick !== tick) begin
      bad++;
      $display("FAIL R4 (%s) leak_tick=%b expected=%b", tag, leak_tick, tick);
    end
    fe = 0;
    for (int s = 0; s < 2; s++) begin
      for (int r = 0; r < NR; r++) begin
        bit inc, clr, up, dn;
        int c;
        c   = m_cnt[s][r];
        inc = v && rk == r && ((s == 0 && (cl == 0 || cl == 2)) || (s == 1 && cl == 1));
        clr = we && (ws == s[0]) && (wd[r*4 +: 4] == 4'hF);
        if (clr) begin
          m_cnt[s][r] = 0; m_frz[s][r] = 0;
        end else if (!m_frz[s][r]) begin
          up = inc && c != 15;
          dn = tick && c != 0;
          if (up && !dn && n_thr != 0 && c + 1 == n_thr) begin
            m_frz[s][r] = 1; fe = 1;
          end
          m_cnt[s][r] = c + int'(up) - int'(dn);
        end
      end
    end
    m_hit = (m_hit && !sc) || fe;
    m_tc  = (n_lim == 0) ? 0 : ((m_tc >= n_lim) ? 0 : m_tc + 1);
    exp_q.push_back({m_hit, pack(1), pack(0)});
    tag_q.push_back(tag);
  endtask

  task automatic ev(int rk, int cl, string tag);
    step(1, rk, cl, 0, 0, '0, 0, tag);
  endtask
  task automatic wr(bit ws, logic [31:0] wd, string tag);
    step(0, 0, 0, 1, ws, wd, 0, tag);
  endtask
  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, '0, 0, tag);
  endtask

  // monitor: pop expected items after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [64:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        total++;
        if (ce_word !== e[31:0] || ue_word !== e[63:32] || thr_hit !== e[64]) begin
          bad++;
          $display("FAIL %s ce=%h/%h ue=%h/%h hit=%b/%b", t,
                   ce_word, e[31:0], ue_word, e[63:32], thr_hit, e[64]);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1; ev_valid = 0; ev_rank = 0; ev_class = 0; sw_wr_en = 0;
    sw_wr_sel = 0; sw_wr_data = 0; sts_clr = 0; frz_thresh = 0; period_limit = 0;
    n_thr = 0; n_lim = 0; m_hit = 0; m_tc = 0;
    for (int s = 0; s < 2; s++)
      for (int r = 0; r < NR; r++) begin m_cnt[s][r] = 0; m_frz[s][r] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    total++;
    if (ce_word !== 0 || ue_word !== 0 || thr_hit !== 0) begin
      bad++;
      $display("FAIL R1 reset ce=%h ue=%h hit=%b expected 0", ce_word, ue_word, thr_hit);
    end

    // R1 R2: packing and class steering
    repeat (3) ev(0, 0, "R1 rank0");
    repeat (2) ev(7, 0, "R1 rank7");
    ev(4, 1, "R2 uncorr");
    repeat (2) ev(4, 2, "R2 aliased");
    ev(5, 3, "R2 reserved");
    // R3 saturation
    repeat (17) ev(3, 0, "R3 saturate");
    // R5 writes
    wr(0, 32'h0000_F000, "R5 clear");
    wr(0, 32'h7777_0E77, "R5 ignored");
    wr(1, 32'h000F_0000, "R5 ue clear");
    // R4 leak
    n_lim = 3;
    idle(25, "R4 leak");
    n_lim = 0;
    idle(4, "R4 disabled");
    // R6 freeze
    n_thr = 5;
    repeat (7) ev(2, 0, "R6 freeze");
    n_lim = 2;
    idle(8, "R6 no leak");
    n_thr = 9;
    repeat (2) ev(2, 0, "R7 thr change");
    step(0, 0, 0, 0, 0, '0, 1, "R9 clear");
    wr(0, 32'h0000_0F00, "R5 thaw");
    ev(2, 0, "R6 after thaw");
    // R9 sticky through thaw, set wins over clear
    n_lim = 0; n_thr = 2;
    repeat (2) ev(6, 1, "R9 ue freeze");
    wr(1, 32'h0F00_0000, "R9 thaw keeps hit");
    step(0, 0, 0, 0, 0, '0, 1, "R9 clear");
    ev(5, 1, "R9 ue");
    step(1, 5, 1, 0, 0, '0, 1, "R9 set beats clear");
    // R8 cancel
    n_thr = 0; n_lim = 4;
    repeat (3) ev(1, 0, "R8 prep");
    while (m_tc < 4) idle(1, "R8 align");
    ev(1, 0, "R8 cancel");
    repeat (20) ev(1, 0, "R8 fill");
    while (m_tc < 4) idle(1, "R8 align");
    ev(1, 0, "R8 saturated");
    while (m_tc < 4) idle(1, "R8 align");
    step(1, 1, 0, 1, 0, 32'h0000_00F0, 0, "R10 clear priority");
    idle(3, "R4 tail");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule